// File: doc/BRIEF.md
# Phase-Strobed Two-Instruction ALU Junction

This block is the arithmetic-logic slice of a small 4-bit processor. It has two instructions: an adder and an equality comparator. Each instruction sits on a shared parallel bus behind its own junction. A 4-bit instruction address is decoded into one select line per address. Only the instruction at the matching address is handed the two clock-phase strobes. The first strobe (phase I) loads both bus operands into that instruction's private operand cache. The third strobe (phase III) makes the instruction put its result and flags on the bus.

The junctions never multiplex the bus. Every instruction slot drives its own result and flag lanes, and the lanes of all slots are OR-ed together. An idle slot therefore drives zeros. Any address that has no instruction yields an all-zero bus. The phase strobes are level inputs sampled on the rising clock edge. A phase III strobe puts a value on the output lanes for exactly the one cycle after that edge.

Top module: `phase_alu_junction`

## Requirements
- R1: Synchronous active-high `rst` clears both outputs and every operand cache. A phase III at the adder address after reset, with no phase I before it, yields result 0 and flags 0. The same at the comparator address yields flags 4'b0100.
- R2: The 4-bit address selects exactly one slot. The adder is at address 1 and the comparator at address 2. A phase strobe reaches only the selected slot, and the cache of every other slot stays unchanged.
- R3: On a clock edge with `phase1` high, the selected slot stores `busA` and `busB`. Later changes on the bus inputs do not alter the stored operands.
- R4: On a clock edge with `phase3` high, the selected slot's result and flags appear on `busResult` and `busFlags` for the following cycle only. In every other cycle both outputs are zero.
- R5: The adder outputs (A + B) mod 16 on `busResult` and the carry-out in flag bit 0. Flag bits 1 and 2 are 0.
- R6: The comparator sets flag bit 2 when all four operand bit pairs match and clears it otherwise. Its result lane and flag bits 0 and 1 are 0.
- R7: Flag bit 3 is reserved and is always 0.
- R8: A phase III at an address with no instruction (any value other than 1 or 2) leaves both outputs at zero. A phase I at such an address leaves the adder and comparator caches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instrAddr | input | 4 | Instruction address from the control bundle |
| phase1 | input | 1 | Phase I strobe: operand capture |
| phase3 | input | 1 | Phase III strobe: result release |
| busA | input | 4 | Operand A lane of the bus |
| busB | input | 4 | Operand B lane of the bus |
| busResult | output | 4 | OR-merged result lane |
| busFlags | output | 4 | OR-merged flag lane (bit 0 carry, bit 2 equal, bit 3 reserved) |

## Verification
The assertions read each output cycle against the address and strobe sampled one edge earlier. They therefore assume that `instrAddr` and `phase3` are stable across each rising edge and that reset is applied from time zero. The stimulus changes every input only on the falling edge and raises at most one phase strobe per cycle. Under these conditions the one-cycle release window and the zero bus between releases can be stated directly in terms of ports.

// File: rtl/phase_alu_pkg.sv
package phase_alu_pkg;
  parameter int ADDR_W = 4;
  parameter int DATA_W = 4;
  parameter int FLAG_W = 4;
  localparam int N_SLOTS = 1 << ADDR_W;
  localparam int CARRY_BIT = 0;
  localparam int EQ_BIT = 2;
  localparam int RSV_BIT = 3;

  typedef enum logic [1:0] {KIND_NONE, KIND_ADD, KIND_EQU} slotKind_t;

  // Per-slot gated phase strobes from control to datapath.
  typedef struct packed {
    logic [N_SLOTS-1:0] captureEn;
    logic [N_SLOTS-1:0] releaseEn;
  } strobes_t;
endpackage

// File: rtl/alu_junction_ctrl.sv
module alu_junction_ctrl
  import phase_alu_pkg::*;
(
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic              phase1,
  input  logic              phase3,
  output strobes_t          strobes
);
  logic [N_SLOTS-1:0] slotSel;

  // One AND term per slot: every address bit must equal the slot's pattern.
  for (genvar s = 0; s < N_SLOTS; s++) begin : g_dec
    localparam logic [ADDR_W-1:0] SLOT_CODE = ADDR_W'(s);
    assign slotSel[s] = &(~(instrAddr ^ SLOT_CODE));
  end

  assign strobes.captureEn = slotSel & {N_SLOTS{phase1}};
  assign strobes.releaseEn = slotSel & {N_SLOTS{phase3}};
endmodule

// File: rtl/alu_slot.sv
module alu_slot
  import phase_alu_pkg::*;
#(
  parameter slotKind_t KIND = KIND_ADD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              captureEn,
  input  logic              releaseEn,
  input  logic [DATA_W-1:0] busA,
  input  logic [DATA_W-1:0] busB,
  output logic [DATA_W-1:0] outRes,
  output logic [FLAG_W-1:0] outFlags
);
  logic [DATA_W-1:0] opA, opB;
  logic [DATA_W-1:0] nextRes;
  logic [FLAG_W-1:0] nextFlags;

  if (KIND == KIND_ADD) begin : g_add
    logic [DATA_W:0] wideSum;
    assign wideSum = {1'b0, opA} + {1'b0, opB};
    always_comb begin
      nextRes = wideSum[DATA_W-1:0];
      nextFlags = '0;
      nextFlags[CARRY_BIT] = wideSum[DATA_W];
    end
  end else begin : g_equ
    logic [DATA_W-1:0] bitMatch;
    assign bitMatch = opA ~^ opB;
    always_comb begin
      nextRes = '0;
      nextFlags = '0;
      nextFlags[EQ_BIT] = &bitMatch;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opA <= '0;
      opB <= '0;
      outRes <= '0;
      outFlags <= '0;
    end else begin
      if (captureEn) begin
        opA <= busA;
        opB <= busB;
      end
      if (releaseEn) begin
        outRes <= nextRes;
        outFlags <= nextFlags;
      end else begin
        outRes <= '0;
        outFlags <= '0;
      end
    end
  end
endmodule

// File: rtl/alu_junction_dp.sv
module alu_junction_dp
  import phase_alu_pkg::*;
#(
  parameter int ADD_SLOT = 1,
  parameter int EQU_SLOT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] busA,
  input  logic [DATA_W-1:0] busB,
  output logic [DATA_W-1:0] busResult,
  output logic [FLAG_W-1:0] busFlags
);
  logic [DATA_W-1:0] slotRes   [N_SLOTS];
  logic [FLAG_W-1:0] slotFlags [N_SLOTS];

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    if (s == ADD_SLOT || s == EQU_SLOT) begin : g_inst
      alu_slot #(
        .KIND(s == ADD_SLOT ? KIND_ADD : KIND_EQU)
      ) u_slot (
        .clk      (clk),
        .rst      (rst),
        .captureEn(strobes.captureEn[s]),
        .releaseEn(strobes.releaseEn[s]),
        .busA     (busA),
        .busB     (busB),
        .outRes   (slotRes[s]),
        .outFlags (slotFlags[s])
      );
    end else begin : g_empty
      logic unusedStrobe;
      assign unusedStrobe = strobes.captureEn[s] | strobes.releaseEn[s];
      assign slotRes[s] = '0;
      assign slotFlags[s] = '0;
    end
  end

  // Wired-OR bus merge: idle slots contribute zeros.
  always_comb begin
    busResult = '0;
    busFlags = '0;
    for (int s = 0; s < N_SLOTS; s++) begin
      busResult = busResult | slotRes[s];
      busFlags = busFlags | slotFlags[s];
    end
    busFlags[RSV_BIT] = 1'b0;
  end
endmodule

// File: rtl/phase_alu_junction.sv
module phase_alu_junction
  import phase_alu_pkg::*;
#(
  parameter int ADD_SLOT = 1,
  parameter int EQU_SLOT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic              phase1,
  input  logic              phase3,
  input  logic [DATA_W-1:0] busA,
  input  logic [DATA_W-1:0] busB,
  output logic [DATA_W-1:0] busResult,
  output logic [FLAG_W-1:0] busFlags
);
  strobes_t strobes;

  alu_junction_ctrl u_ctrl (
    .instrAddr(instrAddr),
    .phase1   (phase1),
    .phase3   (phase3),
    .strobes  (strobes)
  );

  alu_junction_dp #(
    .ADD_SLOT(ADD_SLOT),
    .EQU_SLOT(EQU_SLOT)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .busA     (busA),
    .busB     (busB),
    .busResult(busResult),
    .busFlags (busFlags)
  );
endmodule

// File: rtl/phase_alu_checker.sv
module phase_alu_checker
  import phase_alu_pkg::*;
#(
  parameter int ADD_SLOT = 1,
  parameter int EQU_SLOT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] instrAddr,
  input logic              phase1,
  input logic              phase3,
  input logic [DATA_W-1:0] busA,
  input logic [DATA_W-1:0] busB,
  input logic [DATA_W-1:0] busResult,
  input logic [FLAG_W-1:0] busFlags
);
  logic unusedIn;
  assign unusedIn = phase1 | (|busA) | (|busB);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (busResult == '0 && busFlags == '0));

  assert_release_window_R4: assert property (@(posedge clk) disable iff (rst)
    (busResult != '0 || busFlags != '0) |-> $past(phase3));

  assert_add_lanes_R5: assert property (@(posedge clk) disable iff (rst)
    $past(phase3 && instrAddr == ADDR_W'(ADD_SLOT)) |-> busFlags[EQ_BIT:1] == '0);

  assert_equ_lanes_R6: assert property (@(posedge clk) disable iff (rst)
    $past(phase3 && instrAddr == ADDR_W'(EQU_SLOT))
      |-> (busResult == '0 && busFlags[1:0] == '0));

  assert_reserved_flag_R7: assert property (@(posedge clk) disable iff (rst)
    busFlags[RSV_BIT] == 1'b0);

  assert_unattached_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    $past(instrAddr != ADDR_W'(ADD_SLOT) && instrAddr != ADDR_W'(EQU_SLOT))
      |-> (busResult == '0 && busFlags == '0));
endmodule

bind phase_alu_junction phase_alu_checker #(
  .ADD_SLOT(ADD_SLOT),
  .EQU_SLOT(EQU_SLOT)
) u_chk (.*);

// File: tb/test_phase_alu_junction.sv
module test_phase_alu_junction;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] instrAddr = 4'd0;
  logic phase1 = 1'b0;
  logic phase3 = 1'b0;
  logic [3:0] busA = 4'd0;
  logic [3:0] busB = 4'd0;
  logic [3:0] busResult;
  logic [3:0] busFlags;

  int checks = 0;
  int fails = 0;
  localparam logic [3:0] ADDR_ADD = 4'd1;
  localparam logic [3:0] ADDR_EQU = 4'd2;

  always #10 clk = ~clk;

  phase_alu_junction i_phase_alu_junction (
    .clk(clk), .rst(rst), .instrAddr(instrAddr), .phase1(phase1), .phase3(phase3),
    .busA(busA), .busB(busB), .busResult(busResult), .busFlags(busFlags)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic capture(input logic [3:0] addr, input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    instrAddr = addr; busA = a; busB = b; phase1 = 1'b1; phase3 = 1'b0;
    @(negedge clk);
    phase1 = 1'b0;
    busA = ~a; busB = ~b;
  endtask

  // Raises phase III for one edge, returns the outputs of the following cycle.
  task automatic release_op(input logic [3:0] addr, output logic [3:0] res, output logic [3:0] flg);
    instrAddr = addr; phase3 = 1'b1;
    @(negedge clk);
    phase3 = 1'b0;
    res = busResult; flg = busFlags;
  endtask

  task automatic testReset();
    logic [3:0] r, f;
    check("R1", "result after reset", busResult, 0);
    check("R1", "flags after reset", busFlags, 0);
    release_op(ADDR_ADD, r, f);
    check("R1", "add cache cleared result", r, 0);
    check("R1", "add cache cleared flags", f, 0);
    release_op(ADDR_EQU, r, f);
    check("R1", "equ cache cleared flags", f, 4);
    check("R1", "equ cache cleared result", r, 0);
  endtask

  task automatic testAdd(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] r, f;
    int s;
    s = a + b;
    capture(ADDR_ADD, a, b);
    release_op(ADDR_ADD, r, f);
    check("R5", "add sum", r, s % 16);
    check("R5", "add carry flags", f, (s > 15) ? 1 : 0);
  endtask

  task automatic testEqu(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] r, f;
    capture(ADDR_EQU, a, b);
    release_op(ADDR_EQU, r, f);
    check("R6", "equ flags", f, (a == b) ? 4 : 0);
    check("R6", "equ result lane", r, 0);
    check("R7", "reserved flag bit", f[3], 0);
  endtask

  task automatic testWindow();
    logic [3:0] r, f;
    capture(ADDR_ADD, 4'd6, 4'd5);
    check("R4", "no output after capture only", busResult, 0);
    release_op(ADDR_ADD, r, f);
    check("R4", "released sum", r, 11);
    @(negedge clk);
    check("R4", "result cleared next cycle", busResult, 0);
    check("R4", "flags cleared next cycle", busFlags, 0);
  endtask

  task automatic testCacheIsolation();
    logic [3:0] r, f;
    capture(ADDR_ADD, 4'd2, 4'd3);
    capture(ADDR_EQU, 4'd7, 4'd7);
    busA = 4'd15; busB = 4'd15;
    release_op(ADDR_ADD, r, f);
    check("R3", "add cache kept past bus change", r, 5);
    check("R2", "add cache untouched by equ capture", f, 0);
    release_op(ADDR_EQU, r, f);
    check("R2", "equ only slot on bus", f, 4);
    check("R2", "equ release hides add result", r, 0);
  endtask

  task automatic testUnattached();
    logic [3:0] r, f;
    capture(ADDR_ADD, 4'd9, 4'd4);
    capture(4'd5, 4'd1, 4'd1);
    capture(4'd0, 4'd8, 4'd8);
    release_op(4'd5, r, f);
    check("R8", "unattached result", r, 0);
    check("R8", "unattached flags", f, 0);
    release_op(4'd15, r, f);
    check("R8", "top address quiet", {r, f}, 0);
    release_op(ADDR_ADD, r, f);
    check("R8", "add cache kept after stray capture", r, 13);
    check("R8", "add flags after stray capture", f, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testAdd(4'd3, 4'd4);
    testAdd(4'd9, 4'd8);
    testAdd(4'd15, 4'd15);
    testAdd(4'd8, 4'd8);
    testEqu(4'd5, 4'd5);
    testEqu(4'd5, 4'd4);
    testEqu(4'd0, 4'd8);
    testEqu(4'd15, 4'd15);
    testWindow();
    testCacheIsolation();
    testUnattached();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule